// File: doc/BRIEF.md
# Coherent Diagnostic Measurement Map

This block keeps the live 16-bit monitoring values of an optical transceiver: module temperature, supply voltage, transmit bias current, transmit output power and received optical power. Each value sits in two neighbouring bytes of a 256-byte map, with the high byte at the even address. A host reads the map one byte at a time through a two-wire serial slave that sits in front of this block. That slave decodes the bit-level protocol and passes on transaction start with the device address, pointer loads, byte read strobes and transaction stop. A sampler writes fresh 16-bit words through a valid/ready port.

The block makes sure that a host never sees a torn value. While a matched host transaction is open, the live fields are frozen. Sampler words that arrive in that window are parked in one pending slot per field, and a later word for the same field replaces the earlier one. All parked words are committed in the cycle after the transaction stops. A high-byte read also copies the low byte of the same field into a shadow register, and the next low-byte read returns that shadow. A read-only option byte reports whether the values are internally calibrated or raw counts.

The sampler port applies no back-pressure: `smp_ready` is always high, and a word is taken on every cycle in which `smp_valid` is high. The host read path has no stall. Read data appears one cycle after the strobe.

Top module: `mon_coherent_map`

## Requirements
- R1: A transaction opens only when its 7-bit device address is 7'b1010001 (A2h in 8-bit form); `host_sel` then reads 1. For any other address `host_sel` stays 0, and read strobes and pointer loads are ignored (no `host_rvalid`).
- R2: Field index 0..4 is temperature, supply voltage, TX bias, TX power and RX power, at byte pairs 96/97, 98/99, 100/101, 102/103 and 104/105, with the high byte at the even address.
- R3: Byte 92 reads as the option byte: bit 5 = 1 for internal calibration (default), bit 4 = 1 for external calibration, and all other bits are 0. The default value is 20h.
- R4: Every byte outside 92 and 96..105 reads as 00h.
- R5: Bits below the real resolution of a field read as zero. The default masks are FFFFh for temperature, voltage and TX power, FFFCh for TX bias and FFF0h for RX power.
- R6: A pointer load sets the byte address. Each read advances it by one and wraps from 255 to 0, so that one two-byte read covers a field.
- R7: A sampler word written outside a matched transaction is visible to any later read.
- R8: During a matched transaction the live fields do not change. A read returns the values held at the start of the transaction, even when the sampler writes meanwhile.
- R9: Parked words are committed in the cycle after stop, and a newer parked word for a field replaces an older one. A direct sampler write in the commit cycle wins over the parked word for that field.
- R10: A high-byte read captures the low byte of that field. The following low-byte read of the same field returns the captured byte.
- R11: `smp_ready` is always 1. `host_rvalid` pulses exactly one cycle after an accepted read strobe and at no other time.
- R12: After reset all fields read as 0000h, `host_sel` is 0 and `host_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sampler word valid |
| smp_ready | output | 1 | Sampler ready, always 1 |
| smp_field | input | 3 | Field index of the sampler word |
| smp_data | input | 16 | Sampler word |
| host_start | input | 1 | Transaction start pulse |
| host_dev | input | 7 | Device address of the starting transaction |
| host_stop | input | 1 | Transaction stop pulse |
| host_ptr_valid | input | 1 | Pointer load strobe |
| host_ptr | input | 8 | Pointer value to load |
| host_rd | input | 1 | Byte read strobe |
| host_sel | output | 1 | A matched transaction is open |
| host_rvalid | output | 1 | Read byte valid |
| host_rdata | output | 8 | Read byte |

## Verification
The bench writes to a field while a two-byte read of that same field is in progress. A design that lets the sampler write straight into a live field would return a high byte and a low byte from different samples. It also writes the same field twice inside one transaction and then writes it directly in the commit cycle. A wrong overwrite or commit order would leave an old word in the field. Reads across the 255-to-0 pointer wrap, reads of the option byte and of unused bytes, and an all-ones write into each field check the pointer arithmetic, the address decode and the resolution masks. A transaction with a foreign device address must produce no read data at all.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int unsigned NFIELD = 5;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FIDX_W = $clog2(NFIELD);
  localparam int unsigned MAP_W  = NFIELD * WORD_W;

  typedef enum logic [FIDX_W-1:0] {
    FLD_TEMP  = 3'd0,
    FLD_VOLT  = 3'd1,
    FLD_BIAS  = 3'd2,
    FLD_TXPWR = 3'd3,
    FLD_RXPWR = 3'd4
  } field_e;

  typedef struct packed {
    logic              hit;
    logic              is_lsb;
    logic [FIDX_W-1:0] idx;
  } slot_t;
endpackage

// File: rtl/mon_store.sv
module mon_store
  import mon_pkg::*;
#(
  parameter logic [MAP_W-1:0] RES_MASK = {MAP_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FIDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              hold,
  input  logic              commit,
  output logic [MAP_W-1:0]  live_flat,
  output logic              pend_any
);
  logic [NFIELD-1:0] pend_vld;

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_field
      localparam logic [WORD_W-1:0] FMASK = RES_MASK[g*WORD_W +: WORD_W];
      logic [WORD_W-1:0] live_q;
      logic [WORD_W-1:0] pend_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == FIDX_W'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live_q      <= '0;
          pend_q      <= '0;
          pend_vld[g] <= 1'b0;
        end else begin
          if (hold) begin
            if (hit) begin
              pend_q      <= wr_data & FMASK;
              pend_vld[g] <= 1'b1;
            end
          end else begin
            if (hit) begin
              live_q <= wr_data & FMASK;
            end else if (commit && pend_vld[g]) begin
              live_q <= pend_q;
            end
            if (commit) begin
              pend_vld[g] <= 1'b0;
            end
          end
        end
      end

      assign live_flat[g*WORD_W +: WORD_W] = live_q;
    end
  endgenerate

  assign pend_any = |pend_vld;
endmodule

// File: rtl/mon_byte_map.sv
module mon_byte_map
  import mon_pkg::*;
#(
  parameter int unsigned FIELD_BASE = 96,
  parameter int unsigned OPT_ADDR   = 92
) (
  input  logic [7:0]       addr,
  input  logic [MAP_W-1:0] live_flat,
  input  logic [7:0]       opt_byte,
  output slot_t            slot,
  output logic [7:0]       rbyte,
  output logic [7:0]       lsb_byte
);
  localparam logic [7:0] BASE8 = 8'(FIELD_BASE);
  localparam logic [7:0] SPAN8 = 8'(2 * NFIELD);
  localparam logic [7:0] OPT8  = 8'(OPT_ADDR);

  logic [7:0]        off;
  logic [WORD_W-1:0] word;

  always_comb begin
    off      = addr - BASE8;
    word     = '0;
    slot     = '0;
    rbyte    = 8'h00;
    lsb_byte = 8'h00;
    if (addr >= BASE8 && off < SPAN8) begin
      for (int f = 0; f < NFIELD; f++) begin
        if (off[7:1] == 7'(f)) begin
          word     = live_flat[f*WORD_W +: WORD_W];
          slot.idx = FIDX_W'(f);
        end
      end
      slot.hit    = 1'b1;
      slot.is_lsb = off[0];
      rbyte       = off[0] ? word[7:0] : word[15:8];
      lsb_byte    = word[7:0];
    end else if (addr == OPT8) begin
      rbyte = opt_byte;
    end
  end
endmodule

// File: rtl/mon_host_ctl.sv
module mon_host_ctl
  import mon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] dev,
  input  logic       stop,
  input  logic       ptr_valid,
  input  logic [7:0] ptr_in,
  input  logic       rd,
  input  slot_t      slot,
  input  logic [7:0] rbyte,
  input  logic [7:0] lsb_byte,
  output logic [7:0] ptr,
  output logic       active,
  output logic       commit,
  output logic       rvalid,
  output logic [7:0] rdata
);
  logic              shd_vld;
  logic [FIDX_W-1:0] shd_idx;
  logic [7:0]        shd_byte;
  logic              use_shadow;

  assign use_shadow = slot.hit && slot.is_lsb && shd_vld && (shd_idx == slot.idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      commit   <= 1'b0;
      ptr      <= 8'h00;
      rvalid   <= 1'b0;
      rdata    <= 8'h00;
      shd_vld  <= 1'b0;
      shd_idx  <= '0;
      shd_byte <= 8'h00;
    end else begin
      rvalid <= 1'b0;
      commit <= stop && active;
      if (start) begin
        active  <= (dev == DEV_ADDR);
        shd_vld <= 1'b0;
      end else if (stop) begin
        active  <= 1'b0;
        shd_vld <= 1'b0;
      end
      if (active && !start && !stop) begin
        if (ptr_valid) begin
          ptr <= ptr_in;
        end else if (rd) begin
          ptr    <= ptr + 8'd1;
          rvalid <= 1'b1;
          rdata  <= use_shadow ? shd_byte : rbyte;
          if (slot.hit && !slot.is_lsb) begin
            shd_vld  <= 1'b1;
            shd_idx  <= slot.idx;
            shd_byte <= lsb_byte;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mon_coherent_map.sv
module mon_coherent_map
  import mon_pkg::*;
#(
  parameter logic [6:0]       DEV_ADDR     = 7'b1010001,
  parameter int unsigned      FIELD_BASE   = 96,
  parameter int unsigned      OPT_ADDR     = 92,
  parameter bit               INTERNAL_CAL = 1'b1,
  parameter logic [MAP_W-1:0] RES_MASK     = {16'hFFF0, 16'hFFFF, 16'hFFFC, 16'hFFFF, 16'hFFFF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [FIDX_W-1:0] smp_field,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              host_start,
  input  logic [6:0]        host_dev,
  input  logic              host_stop,
  input  logic              host_ptr_valid,
  input  logic [7:0]        host_ptr,
  input  logic              host_rd,
  output logic              host_sel,
  output logic              host_rvalid,
  output logic [7:0]        host_rdata
);
  logic [MAP_W-1:0] live_flat;
  logic             pend_any;
  logic             active;
  logic             commit;
  logic [7:0]       ptr;
  logic [7:0]       opt_byte;
  logic [7:0]       rbyte;
  logic [7:0]       lsb_byte;
  slot_t            slot;

  assign smp_ready = 1'b1;
  assign opt_byte  = {2'b00, INTERNAL_CAL, ~INTERNAL_CAL, 4'b0000};
  assign host_sel  = active;

  mon_store #(.RES_MASK(RES_MASK)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (smp_valid && smp_ready),
    .wr_idx    (smp_field),
    .wr_data   (smp_data),
    .hold      (active),
    .commit    (commit),
    .live_flat (live_flat),
    .pend_any  (pend_any)
  );

  mon_byte_map #(.FIELD_BASE(FIELD_BASE), .OPT_ADDR(OPT_ADDR)) u_map (
    .addr      (ptr),
    .live_flat (live_flat),
    .opt_byte  (opt_byte),
    .slot      (slot),
    .rbyte     (rbyte),
    .lsb_byte  (lsb_byte)
  );

  mon_host_ctl #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (host_start),
    .dev       (host_dev),
    .stop      (host_stop),
    .ptr_valid (host_ptr_valid),
    .ptr_in    (host_ptr),
    .rd        (host_rd),
    .slot      (slot),
    .rbyte     (rbyte),
    .lsb_byte  (lsb_byte),
    .ptr       (ptr),
    .active    (active),
    .commit    (commit),
    .rvalid    (host_rvalid),
    .rdata     (host_rdata)
  );
endmodule

// File: rtl/mon_map_chk.sv
module mon_map_chk
  import mon_pkg::*;
#(
  parameter int unsigned OPT_ADDR = 92
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             commit,
  input logic             pend_any,
  input logic             host_rd,
  input logic             host_ptr_valid,
  input logic             host_start,
  input logic             host_stop,
  input logic [7:0]       ptr,
  input logic [7:0]       opt_byte,
  input logic             host_rvalid,
  input logic [7:0]       host_rdata,
  input logic [MAP_W-1:0] live_flat
);
  // R8
  frozen_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) |-> $stable(live_flat));

  // R11
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_rd && active));

  // R9
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> !pend_any);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active && host_rd && !host_ptr_valid && !host_start && !host_stop)
      |-> ptr == $past(ptr) + 8'd1);

  // R3
  opt_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(ptr) == 8'(OPT_ADDR)) |-> host_rdata == opt_byte);

  // R4
  low_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(ptr) < 8'(OPT_ADDR)) |-> host_rdata == 8'h00);
endmodule

bind mon_coherent_map mon_map_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .active         (active),
  .commit         (commit),
  .pend_any       (pend_any),
  .host_rd        (host_rd),
  .host_ptr_valid (host_ptr_valid),
  .host_start     (host_start),
  .host_stop      (host_stop),
  .ptr            (ptr),
  .opt_byte       (opt_byte),
  .host_rvalid    (host_rvalid),
  .host_rdata     (host_rdata),
  .live_flat      (live_flat)
);

// File: tb/sim_mon_coherent_map.sv
module sim_mon_coherent_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [2:0]  smp_field = '0;
  logic [15:0] smp_data = '0;
  logic        host_start = 1'b0;
  logic [6:0]  host_dev = '0;
  logic        host_stop = 1'b0;
  logic        host_ptr_valid = 1'b0;
  logic [7:0]  host_ptr = '0;
  logic        host_rd = 1'b0;
  logic        host_sel;
  logic        host_rvalid;
  logic [7:0]  host_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_live [5];
  logic [15:0] m_pend [5];
  bit          m_pv   [5];
  bit          m_open = 1'b0;

  always #10 clk = ~clk;

  mon_coherent_map u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_field(smp_field), .smp_data(smp_data), .host_start(host_start),
    .host_dev(host_dev), .host_stop(host_stop), .host_ptr_valid(host_ptr_valid),
    .host_ptr(host_ptr), .host_rd(host_rd), .host_sel(host_sel),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata)
  );

  // R5 default resolution masks
  function automatic logic [15:0] res_mask(input int f);
    case (f)
      2: return 16'hFFFC;
      4: return 16'hFFF0;
      default: return 16'hFFFF;
    endcase
  endfunction

  // R2, R3, R4 expected byte from the model
  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    if (a >= 8'd96 && a <= 8'd105)
      return a[0] ? m_live[(a - 8'd96) >> 1][7:0] : m_live[(a - 8'd96) >> 1][15:8];
    if (a == 8'd92) return 8'h20;
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int f, input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_field = 3'(f); smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
    if (m_open) begin m_pend[f] = d & res_mask(f); m_pv[f] = 1'b1; end
    else begin m_live[f] = d & res_mask(f); end
  endtask

  task automatic start(input logic [6:0] dev);
    @(negedge clk);
    host_start = 1'b1; host_dev = dev;
    @(negedge clk);
    host_start = 1'b0;
    m_open = (dev == 7'b1010001);
  endtask

  task automatic stop();
    @(negedge clk);
    host_stop = 1'b1;
    @(negedge clk);
    host_stop = 1'b0;
    if (m_open) begin
      for (int f = 0; f < 5; f++) if (m_pv[f]) begin m_live[f] = m_pend[f]; m_pv[f] = 1'b0; end
    end
    m_open = 1'b0;
  endtask

  task automatic setptr(input logic [7:0] a);
    @(negedge clk);
    host_ptr_valid = 1'b1; host_ptr = a;
    @(negedge clk);
    host_ptr_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b, output logic v);
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    b = host_rdata; v = host_rvalid;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
    logic [7:0] b; logic v;
    rd(b, v);
    chk(v == 1'b1, req, v, 1);
    chk(b == e, req, b, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b; logic v; logic [15:0] snap;
    void'($urandom(32'd4242));
    for (int f = 0; f < 5; f++) begin m_live[f] = '0; m_pend[f] = '0; m_pv[f] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state, R11 ready
    chk(host_sel == 1'b0, "R12", host_sel, 0);
    chk(host_rvalid == 1'b0, "R12", host_rvalid, 0);
    chk(smp_ready == 1'b1, "R11", smp_ready, 1);
    start(7'b1010001);
    chk(host_sel == 1'b1, "R1", host_sel, 1);
    setptr(8'd96);
    for (int a = 96; a < 106; a++) rd_chk(8'(a), 8'h00, "R12");
    // R11 rvalid returns low after one cycle
    @(negedge clk);
    chk(host_rvalid == 1'b0, "R11", host_rvalid, 0);
    stop();

    // R1 foreign address
    start(7'b1010000);
    chk(host_sel == 1'b0, "R1", host_sel, 0);
    setptr(8'd92);
    rd(b, v);
    chk(v == 1'b0, "R1", v, 0);
    stop();

    // R7 idle write then R5 masks with all ones
    for (int f = 0; f < 5; f++) wr(f, 16'hFFFF);
    start(7'b1010001);
    setptr(8'd96);
    for (int f = 0; f < 5; f++) begin
      rd_chk(8'(96 + 2*f), res_mask(f)[15:8], "R5");
      rd_chk(8'(97 + 2*f), res_mask(f)[7:0], "R5");
    end
    // R3 option byte, R4 holes
    setptr(8'd92);
    rd_chk(8'd92, 8'h20, "R3");
    rd_chk(8'd93, 8'h00, "R4");
    setptr(8'd0);
    rd_chk(8'd0, 8'h00, "R4");
    setptr(8'd91);
    rd_chk(8'd91, 8'h00, "R4");
    // R6 wrap 255 -> 0, and 105 -> 106
    setptr(8'd255);
    rd_chk(8'd255, 8'h00, "R6");
    rd_chk(8'd0, 8'h00, "R6");
    setptr(8'd105);
    rd_chk(8'd105, exp_byte(8'd105), "R6");
    rd_chk(8'd106, 8'h00, "R4");
    stop();

    // R7 distinct values per field, R2 layout
    wr(0, 16'h1234); wr(1, 16'h5678); wr(2, 16'h9ABC); wr(3, 16'hDEF0); wr(4, 16'h0FE1);
    start(7'b1010001);
    setptr(8'd96);
    for (int a = 96; a < 106; a++) rd_chk(8'(a), exp_byte(8'(a)), "R2");
    stop();

    // R8 R10 write to the field between its MSB and LSB reads
    start(7'b1010001);
    setptr(8'd104);
    snap = m_live[4];
    rd_chk(8'd104, snap[15:8], "R8");
    wr(4, 16'hAAAA);
    wr(4, 16'h5555);
    rd_chk(8'd105, snap[7:0], "R10");
    stop();
    // R9 newest parked word committed
    start(7'b1010001);
    setptr(8'd104);
    rd_chk(8'd104, 8'h55, "R9");
    rd_chk(8'd105, 8'h50, "R9");
    wr(0, 16'h7777);
    // R9 direct write in commit cycle wins
    @(negedge clk);
    host_stop = 1'b1;
    @(negedge clk);
    host_stop = 1'b0;
    smp_valid = 1'b1; smp_field = 3'd0; smp_data = 16'h3C3C;
    @(negedge clk);
    smp_valid = 1'b0;
    m_open = 1'b0; m_pv[0] = 1'b0; m_live[0] = 16'h3C3C;
    start(7'b1010001);
    setptr(8'd96);
    rd_chk(8'd96, 8'h3C, "R9");
    rd_chk(8'd97, 8'h3C, "R9");
    stop();

    // Random phase: R8 R10 coherent two-byte reads with concurrent writes
    for (int it = 0; it < 60; it++) begin
      int f, nw;
      nw = int'($urandom_range(0, 2));
      for (int k = 0; k < nw; k++) wr(int'($urandom_range(0, 4)), 16'($urandom));
      f = int'($urandom_range(0, 4));
      start(7'b1010001);
      setptr(8'(96 + 2*f));
      snap = m_live[f];
      rd_chk(8'(96 + 2*f), snap[15:8], "R8");
      if ($urandom_range(0, 1) == 1) wr(f, 16'($urandom));
      if ($urandom_range(0, 1) == 1) wr(int'($urandom_range(0, 4)), 16'($urandom));
      rd_chk(8'(97 + 2*f), snap[7:0], "R10");
      stop();
    end
    // R9 final readback of every field after random commits
    start(7'b1010001);
    setptr(8'd96);
    for (int a = 96; a < 106; a++) rd_chk(8'(a), exp_byte(8'(a)), "R9");
    stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule